// File: doc/BRIEF.md
# Multi-Level Pulse Programming Controller

This block decodes an end-of-line trim stream that arrives on a supply rail as three voltage levels. External comparators classify the rail into a 2-bit level code, and the block samples it on a system clock. It first qualifies each level by the minimum time it is held. It then frames the qualified pulses into keys and increments and walks a state machine. That machine picks a programming mode, then a parameter register, and then raises that register's code one step for each mid-level pulse.

Two modes are supported. In the trial mode, codes are held in volatile registers. Several parameters can be tuned together, and they are lost at the next power-cycle reset. In the permanent mode, one parameter is addressed per power cycle, and a long high pulse burns the top set bit of its code into an emulated one-time fuse. Fuses survive reset and accumulate by OR. A dedicated lock fuse, once set, freezes all further programming. The outputs are the effective trim codes for sensitivity, quiescent duty, carrier frequency and the calibration enable. Each is the OR of that register's fuse and volatile values.

The stream is built from frames. A high pulse opens a frame, and the mid pulses that follow form the key. The next high pulse closes the frame and also opens the next step. The full stream is: high, mode key, high, parameter key, high, increment pulses, closing high.

Top module: `mlp_prog_ctrl`

## Requirements
- R1: The level input is coded 0 = low, 1 = mid, 2 = high, 3 = invalid. A level counts only after it has been held for MIN_W consecutive clocks. Shorter excursions, including short lows inside a pulse, are ignored.
- R2: The mode key is the number of mid pulses between the first two high pulses. Key 1 selects permanent (fuse) mode, key 2 selects trial mode, and any other key returns the sequencer to idle. In idle, mid pulses are ignored.
- R3: The parameter key is the number of mid pulses before the next high pulse. Key 1 selects sensitivity, 2 selects quiescent duty, 3 selects carrier/calibration, and 6 selects lock. Key 6 is accepted only in permanent mode. Any other key returns to idle without changing a code.
- R4: While a register is addressed, each qualified mid pulse raises its code by one when the pulse ends. Codes never decrease before reset. They saturate at 511 for sensitivity and quiescent duty, 31 for carrier/calibration, and 512 for lock.
- R5: In the carrier/calibration register, bits 3..0 form the carrier frequency code and bit 4 is the calibration-mode enable.
- R6: In trial mode, a high pulse after addressing returns to parameter selection. Values set for several registers are all held together, and a register selected again keeps counting from its current code.
- R7: In permanent mode, a closing high pulse held at least BLOW_W clocks ORs the highest set bit of the addressed code into that register's fuse. After this, every input is ignored until reset. A shorter closing high burns nothing and returns to idle.
- R8: Reset clears every volatile code and leaves the fuses unchanged. Each output equals its fuse value ORed with its volatile value.
- R9: Burning bit 9 of the lock register (code 512) sets `locked`. From then on no programming sequence changes any output, across resets.
- R10: An invalid level code, or a step directly between mid and high without a qualified low, aborts the sequence back to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-cycle reset; clears volatile state only |
| fuse_erase | input | 1 | Blank-part initialisation of the emulated fuse array |
| lvl_in | input | 2 | Classified supply level: 0 low, 1 mid, 2 high, 3 invalid |
| sens_code | output | 9 | Effective sensitivity trim code |
| qdc_code | output | 9 | Effective quiescent duty trim code |
| freq_code | output | 4 | Effective carrier frequency trim code |
| cal_en | output | 1 | Effective calibration-mode enable |
| locked | output | 1 | Lock fuse state |

## Verification
The assertions assume that `fuse_erase` is pulsed once, together with reset, before any stream arrives. They also assume that the level input only changes in ways the comparators could produce, so a level change after reset reflects a level that was actually present on the input. The stimulus drives every level for whole clock periods, changes it only between edges, holds real pulses and separators well past MIN_W, and makes glitches strictly shorter than MIN_W. Permanent-mode pulses are held beyond BLOW_W, and short closing highs stay well under it, so no case falls on a threshold.

// File: rtl/mlp_prog_pkg.sv
package mlp_prog_pkg;

    localparam int SENS_W   = 9;
    localparam int QDC_W    = 9;
    localparam int CAR_W    = 5;
    localparam int FREQ_W   = CAR_W - 1;
    localparam int LOCK_BIT = 9;
    localparam int CODE_W   = LOCK_BIT + 1;
    localparam int NREG     = 4;
    localparam int KEY_W    = 3;

    typedef enum logic [1:0] {
        LV_LOW  = 2'd0,
        LV_MID  = 2'd1,
        LV_HIGH = 2'd2,
        LV_BAD  = 2'd3
    } lvl_e;

    typedef enum logic [1:0] {
        RG_SENS = 2'd0,
        RG_QDC  = 2'd1,
        RG_CAR  = 2'd2,
        RG_LOCK = 2'd3
    } reg_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MODE,
        ST_PARAM,
        ST_ADDR,
        ST_SPENT
    } st_e;

    typedef enum logic {
        MD_TRIAL,
        MD_BURN
    } mode_e;

    // one completed, qualified mid or high pulse
    typedef struct packed {
        logic valid;
        lvl_e lvl;
        logic long_hi;
    } pulse_t;

    typedef struct packed {
        logic ok;
        reg_e rg;
    } keymap_t;

    typedef logic [NREG-1:0][CODE_W-1:0] codes_t;

    function automatic logic [CODE_W-1:0] reg_max(input int idx);
        logic [CODE_W-1:0] m;
        case (idx)
            0:       m = CODE_W'((1 << SENS_W) - 1);
            1:       m = CODE_W'((1 << QDC_W) - 1);
            2:       m = CODE_W'((1 << CAR_W) - 1);
            default: m = CODE_W'(1 << LOCK_BIT);
        endcase
        return m;
    endfunction

    function automatic logic [CODE_W-1:0] top_bit(input logic [CODE_W-1:0] v);
        logic [CODE_W-1:0] r;
        r = '0;
        for (int i = 0; i < CODE_W; i++) begin
            if (v[i]) r = CODE_W'(1) << i;
        end
        return r;
    endfunction

    function automatic keymap_t map_key(input logic [KEY_W-1:0] k, input mode_e md);
        keymap_t km;
        km.ok = 1'b1;
        km.rg = RG_SENS;
        case (k)
            3'd1:    km.rg = RG_SENS;
            3'd2:    km.rg = RG_QDC;
            3'd3:    km.rg = RG_CAR;
            3'd6: begin
                km.rg = RG_LOCK;
                km.ok = (md == MD_BURN);
            end
            default: km.ok = 1'b0;
        endcase
        return km;
    endfunction

endpackage

// File: rtl/lvl_filter.sv
module lvl_filter
    import mlp_prog_pkg::*;
#(
    parameter int MIN_W = 40
) (
    input  logic clk,
    input  logic rst,
    input  lvl_e raw,
    output lvl_e filt
);
    localparam int CNT_W = $clog2(MIN_W + 1);

    lvl_e             cand;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            filt <= LV_LOW;
            cand <= LV_LOW;
            cnt  <= '0;
        end else if (raw == filt) begin
            cnt <= '0;
        end else if (raw != cand) begin
            cand <= raw;
            cnt  <= CNT_W'(1);
        end else if (cnt >= CNT_W'(MIN_W - 1)) begin
            filt <= raw;
            cnt  <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/pulse_tracker.sv
module pulse_tracker
    import mlp_prog_pkg::*;
#(
    parameter int BLOW_W = 100
) (
    input  logic   clk,
    input  logic   rst,
    input  lvl_e   filt,
    output pulse_t done,
    output logic   abort
);
    localparam int DUR_W = $clog2(BLOW_W + 1);

    lvl_e             prev;
    logic [DUR_W-1:0] dur;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= LV_LOW;
            dur  <= '0;
        end else begin
            prev <= filt;
            if (filt == LV_LOW)
                dur <= '0;
            else if (dur != DUR_W'(BLOW_W))
                dur <= dur + DUR_W'(1);
        end
    end

    always_comb begin
        done.valid   = (filt == LV_LOW) && ((prev == LV_MID) || (prev == LV_HIGH));
        done.lvl     = prev;
        done.long_hi = (dur >= DUR_W'(BLOW_W));
        abort        = (filt != prev) &&
                       ((filt == LV_BAD) || ((prev != LV_LOW) && (filt != LV_LOW)));
    end

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import mlp_prog_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  pulse_t pl,
    input  logic   abort,
    input  logic   locked,
    output logic   inc,
    output logic   burn,
    output reg_e   sel
);
    st_e              st;
    mode_e            mode;
    logic [KEY_W-1:0] key;
    keymap_t          km;

    logic is_mid, is_high;

    always_comb begin
        is_mid  = pl.valid && (pl.lvl == LV_MID);
        is_high = pl.valid && (pl.lvl == LV_HIGH);
        km      = map_key(key, mode);
        inc     = is_mid && (st == ST_ADDR);
        burn    = is_high && (st == ST_ADDR) && (mode == MD_BURN) && pl.long_hi;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            mode <= MD_TRIAL;
            key  <= '0;
            sel  <= RG_SENS;
        end else if (st == ST_SPENT) begin
            st <= ST_SPENT;
        end else if (abort) begin
            st  <= ST_IDLE;
            key <= '0;
        end else if (is_mid) begin
            if ((st == ST_MODE || st == ST_PARAM) && key != '1)
                key <= key + KEY_W'(1);
        end else if (is_high) begin
            key <= '0;
            case (st)
                ST_IDLE: begin
                    if (!locked) st <= ST_MODE;
                end
                ST_MODE: begin
                    if (key == KEY_W'(1)) begin
                        mode <= MD_BURN;
                        st   <= ST_PARAM;
                    end else if (key == KEY_W'(2)) begin
                        mode <= MD_TRIAL;
                        st   <= ST_PARAM;
                    end else begin
                        st <= ST_IDLE;
                    end
                end
                ST_PARAM: begin
                    if (km.ok) begin
                        sel <= km.rg;
                        st  <= ST_ADDR;
                    end else begin
                        st <= ST_IDLE;
                    end
                end
                ST_ADDR: begin
                    if (mode == MD_TRIAL)
                        st <= ST_PARAM;
                    else if (pl.long_hi)
                        st <= ST_SPENT;
                    else
                        st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/trim_store.sv
module trim_store
    import mlp_prog_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   fuse_erase,
    input  logic   inc,
    input  logic   burn,
    input  reg_e   sel,
    output codes_t temp_q,
    output codes_t fuse_q
);
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam logic [CODE_W-1:0] MAXC = reg_max(i);
        logic hit;
        assign hit = (int'(sel) == i);

        always_ff @(posedge clk) begin
            if (rst)
                temp_q[i] <= '0;
            else if (inc && hit && temp_q[i] < MAXC)
                temp_q[i] <= temp_q[i] + CODE_W'(1);
        end

        // emulated one-time fuses: untouched by the power-cycle reset
        always_ff @(posedge clk) begin
            if (fuse_erase)
                fuse_q[i] <= '0;
            else if (burn && hit)
                fuse_q[i] <= fuse_q[i] | top_bit(temp_q[i]);
        end
    end

endmodule

// File: rtl/mlp_prog_ctrl.sv
module mlp_prog_ctrl
    import mlp_prog_pkg::*;
#(
    parameter int MIN_W  = 40,
    parameter int BLOW_W = 100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fuse_erase,
    input  logic [1:0]        lvl_in,
    output logic [SENS_W-1:0] sens_code,
    output logic [QDC_W-1:0]  qdc_code,
    output logic [FREQ_W-1:0] freq_code,
    output logic              cal_en,
    output logic              locked
);
    lvl_e   filt_lvl;
    pulse_t pl;
    logic   abort;
    logic   inc_stb;
    logic   blow_stb;
    reg_e   sel;
    codes_t temp_q;
    codes_t fuse_q;
    codes_t eff;

    lvl_filter #(.MIN_W(MIN_W)) u_filt (
        .clk  (clk),
        .rst  (rst),
        .raw  (lvl_e'(lvl_in)),
        .filt (filt_lvl)
    );

    pulse_tracker #(.BLOW_W(BLOW_W)) u_trk (
        .clk   (clk),
        .rst   (rst),
        .filt  (filt_lvl),
        .done  (pl),
        .abort (abort)
    );

    seq_fsm u_seq (
        .clk    (clk),
        .rst    (rst),
        .pl     (pl),
        .abort  (abort),
        .locked (locked),
        .inc    (inc_stb),
        .burn   (blow_stb),
        .sel    (sel)
    );

    trim_store u_store (
        .clk        (clk),
        .rst        (rst),
        .fuse_erase (fuse_erase),
        .inc        (inc_stb),
        .burn       (blow_stb),
        .sel        (sel),
        .temp_q     (temp_q),
        .fuse_q     (fuse_q)
    );

    always_comb begin
        for (int i = 0; i < NREG; i++) eff[i] = temp_q[i] | fuse_q[i];
        sens_code = eff[RG_SENS][SENS_W-1:0];
        qdc_code  = eff[RG_QDC][QDC_W-1:0];
        freq_code = eff[RG_CAR][FREQ_W-1:0];
        cal_en    = eff[RG_CAR][FREQ_W];
        locked    = fuse_q[RG_LOCK][LOCK_BIT];
    end

endmodule

// File: rtl/mlp_prog_chk.sv
module mlp_prog_chk
    import mlp_prog_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       fuse_erase,
    input logic       locked,
    input logic [1:0] lvl_in,
    input lvl_e       filt_lvl,
    input logic       blow_stb,
    input codes_t     temp_q,
    input codes_t     fuse_q
);
    logic burned;

    always_ff @(posedge clk) begin
        if (rst)
            burned <= 1'b0;
        else if (blow_stb)
            burned <= 1'b1;
    end

    // R1: a qualified level always equals the raw level seen just before
    p_filter_follow_r1: assert property (@(posedge clk) disable iff (rst)
        (!$stable(filt_lvl) && !$past(rst)) |-> ($past(lvl_in) == 2'(filt_lvl)));

    // R4: volatile codes never decrease between resets
    p_no_decrement_r4: assert property (@(posedge clk) disable iff (rst || fuse_erase)
        1'b1 |=> (temp_q[0] >= $past(temp_q[0])) && (temp_q[1] >= $past(temp_q[1]))
              && (temp_q[2] >= $past(temp_q[2])));

    // R4: carrier/calibration register stops at its maximum
    p_car_sat_r4: assert property (@(posedge clk) disable iff (rst || fuse_erase)
        temp_q[2] <= CODE_W'(31));

    // R7: at most one burn per power cycle
    p_one_burn_r7: assert property (@(posedge clk) disable iff (rst || fuse_erase)
        blow_stb |-> !burned);

    // R8: fuse bits, once set, stay set through resets
    p_fuse_keep_r8: assert property (@(posedge clk) disable iff (fuse_erase)
        1'b1 |=> ((fuse_q & $past(fuse_q)) == $past(fuse_q)));

    // R9: lock only arises from a burn
    p_lock_by_burn_r9: assert property (@(posedge clk) disable iff (rst || fuse_erase)
        $rose(locked) |-> $past(blow_stb));

    // R9: with the lock set, volatile codes do not move
    p_lock_freeze_r9: assert property (@(posedge clk) disable iff (rst || fuse_erase)
        locked |=> $stable(temp_q));

endmodule

bind mlp_prog_ctrl mlp_prog_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .fuse_erase (fuse_erase),
    .locked     (locked),
    .lvl_in     (lvl_in),
    .filt_lvl   (filt_lvl),
    .blow_stb   (blow_stb),
    .temp_q     (temp_q),
    .fuse_q     (fuse_q)
);

// File: tb/test_mlp_prog_ctrl.sv
module test_mlp_prog_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int MIN_W      = 4;
    localparam int BLOW_W     = 16;
    localparam int PW         = 6;
    localparam int GAP        = 6;
    localparam int WD_CYCLES  = 190000;

    logic       clk = 1'b0;
    logic       rst;
    logic       fuse_erase;
    logic [1:0] lvl_in;
    logic [8:0] sens_code;
    logic [8:0] qdc_code;
    logic [3:0] freq_code;
    logic       cal_en;
    logic       locked;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    mlp_prog_ctrl #(.MIN_W(MIN_W), .BLOW_W(BLOW_W)) i_mlp_prog_ctrl (
        .clk        (clk),
        .rst        (rst),
        .fuse_erase (fuse_erase),
        .lvl_in     (lvl_in),
        .sens_code  (sens_code),
        .qdc_code   (qdc_code),
        .freq_code  (freq_code),
        .cal_en     (cal_en),
        .locked     (locked)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic hold(input logic [1:0] l, input int n);
        lvl_in = l;
        repeat (n) @(negedge clk);
    endtask

    task automatic pls(input logic [1:0] l, input int n);
        hold(l, n);
        hold(2'd0, GAP);
    endtask

    task automatic mids(input int k);
        for (int i = 0; i < k; i++) pls(2'd1, PW);
    endtask

    task automatic hi();
        pls(2'd2, PW);
    endtask

    task automatic burnhi();
        pls(2'd2, BLOW_W + 4);
    endtask

    task automatic frame(input int md, input int prm);
        hi(); mids(md); hi(); mids(prm); hi();
    endtask

    task automatic settle();
        hold(2'd0, 8);
    endtask

    task automatic pcycle();
        rst = 1'b1;
        hold(2'd0, 2);
        rst = 1'b0;
        hold(2'd0, 2);
    endtask

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    initial begin
        int exp3;
        int pts[5];
        rst = 1'b1;
        fuse_erase = 1'b1;
        lvl_in = 2'd0;
        repeat (4) @(negedge clk);
        fuse_erase = 1'b0;
        rst = 1'b0;
        hold(2'd0, 2);

        // reset state (R8)
        chk("R8 reset sens", sens_code, 0);
        chk("R8 reset qdc", qdc_code, 0);
        chk("R8 reset freq", freq_code, 0);
        chk("R8 reset cal", cal_en, 0);
        chk("R9 reset locked", locked, 0);

        // carrier/calibration sweep (R4, R5)
        for (int k = 0; k <= 35; k++) begin
            pcycle();
            frame(2, 3);
            mids(k);
            settle();
            exp3 = imin(k, 31);
            chk("R5 freq field", freq_code, exp3 % 16);
            chk("R5 cal bit4", cal_en, exp3 / 16);
            chk("R4 sens untouched", sens_code, 0);
        end

        // 9-bit registers around saturation (R4)
        pts = '{0, 1, 255, 511, 515};
        foreach (pts[j]) begin
            pcycle();
            frame(2, 1);
            mids(pts[j]);
            settle();
            chk("R4 sens count", sens_code, imin(pts[j], 511));
        end
        pcycle();
        frame(2, 2);
        mids(513);
        settle();
        chk("R4 qdc saturate", qdc_code, 511);

        // trial loop, several registers held (R6)
        pcycle();
        frame(2, 1); mids(5);
        hi(); mids(2); hi(); mids(7);
        hi(); mids(3); hi(); mids(17);
        settle();
        chk("R6 sens held", sens_code, 5);
        chk("R6 qdc held", qdc_code, 7);
        chk("R6 freq held", freq_code, 1);
        chk("R6 cal held", cal_en, 1);
        hi(); mids(1); hi(); mids(2);
        settle();
        chk("R6 reselect continues", sens_code, 7);
        pcycle();
        chk("R8 volatile cleared sens", sens_code, 0);
        chk("R8 volatile cleared qdc", qdc_code, 0);

        // glitch rejection (R1)
        pcycle();
        frame(2, 1); mids(3);
        for (int g = 0; g < 3; g++) pls(2'd1, 2);
        settle();
        chk("R1 short mids ignored", sens_code, 3);
        hold(2'd1, PW); hold(2'd0, 2); hold(2'd1, PW); hold(2'd0, GAP);
        settle();
        chk("R1 short low ignored", sens_code, 4);

        // bad mode key (R2)
        pcycle();
        hi(); mids(3); hi(); mids(1); hi(); mids(4);
        settle();
        chk("R2 bad mode key", sens_code, 0);
        chk("R2 bad mode key qdc", qdc_code, 0);

        // bad parameter keys (R3)
        pcycle();
        frame(2, 4); mids(5);
        settle();
        chk("R3 key 4 sens", sens_code, 0);
        chk("R3 key 4 qdc", qdc_code, 0);
        chk("R3 key 4 freq", freq_code, 0);
        pcycle();
        frame(2, 6); mids(5); hi(); mids(3);
        settle();
        chk("R3 lock key in trial", locked, 0);
        chk("R3 lock key in trial freq", freq_code, 0);

        // out-of-sequence aborts (R10)
        pcycle();
        frame(2, 1); mids(2);
        hold(2'd3, PW); hold(2'd0, GAP);
        mids(4);
        settle();
        chk("R10 invalid level aborts", sens_code, 2);
        pcycle();
        frame(2, 2); mids(1);
        hold(2'd1, PW); hold(2'd2, PW); hold(2'd0, GAP);
        mids(3);
        settle();
        chk("R10 mid to high aborts", qdc_code, 1);

        // permanent mode (R7, R8)
        pcycle();
        frame(1, 1); mids(5); burnhi();
        settle();
        chk("R7 burn keeps volatile", sens_code, 5);
        frame(2, 2); mids(3);
        settle();
        chk("R7 spent ignores input", qdc_code, 0);
        pcycle();
        chk("R7 top bit burned", sens_code, 4);
        frame(1, 1); mids(1); burnhi();
        pcycle();
        chk("R8 fuses OR", sens_code, 5);
        frame(1, 1); mids(2); burnhi();
        pcycle();
        chk("R8 fuses OR again", sens_code, 7);
        frame(1, 2); mids(6); hi();
        settle();
        chk("R7 short high volatile", qdc_code, 6);
        pcycle();
        chk("R7 short high no burn", qdc_code, 0);
        frame(2, 1); mids(8);
        settle();
        chk("R8 fuse or volatile", sens_code, 15);

        // lock (R9)
        pcycle();
        frame(1, 6); mids(515); burnhi();
        settle();
        chk("R9 locked set", locked, 1);
        pcycle();
        chk("R9 lock survives reset", locked, 1);
        frame(2, 2); mids(4);
        hi(); mids(1); hi(); mids(9);
        settle();
        chk("R9 locked qdc frozen", qdc_code, 0);
        chk("R9 locked sens frozen", sens_code, 7);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        finished = 1'b1;
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!finished) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", WD_CYCLES, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule